// File: doc/BRIEF.md
# Region-Targeted Scan Stimulus Generator

This block feeds a set of parallel scan chains during a power-analysis trust test. The scan cells of the design under test are grouped into chains by layout region. The goal is to keep switching activity inside one chosen region. The host picks the chain that covers that region, a seed, a chain length in shift cycles and a number of patterns, and then pulses start.

While a run is active, scan enable stays high on every cycle, so shifting and capture overlap in test-per-clock fashion. A 16-bit pseudo-random generator supplies one fresh bit per cycle to the selected chain. Every other chain sees a steady zero. The block counts shift cycles and completed patterns. When the last pattern ends, it drops scan enable, drives every scan-in to zero and holds a done flag.

A start request that names a chain outside the configured range is refused. In that case the block raises an error flag and does not begin a run.

Top module: `region_scan_gen`

## Requirements
- R1: A start pulse with a valid index (target < NUM_CHAINS), given while no run is active, begins a run on the next clock edge. From the following cycle scan_en_o is 1, the counters are cleared and the generator holds the seed. A zero seed is replaced by 16'hACE1.
- R2: During a run, the selected chain's scan-in equals bit 0 of the generator state. The generator shifts right once per cycle and, when the outgoing bit 0 was 1, XORs in the mask 16'hB400. The first shifted bit is therefore seed bit 0.
- R3: During a run, every scan-in other than the selected chain's is 0 on every cycle. scan_in_o bit k drives chain k.
- R4: scan_en_o stays 1 without a break for exactly chain_len × pattern_count cycles and never pulses low in between.
- R5: patterns_o counts completed patterns: it rises by one after each chain_len shift cycles and ends equal to pattern_count. A chain length or pattern count of 0 is treated as 1. patterns_o does not change outside a run.
- R6: After the last pattern, scan_en_o is 0, all scan-in outputs are 0 and done_o is 1. done_o stays 1 until the next start request, whether that request is accepted or refused.
- R7: The index, seed, length and count are captured at start. A start pulse during a run is ignored, and so are changes to these inputs.
- R8: A start whose index is NUM_CHAINS or more sets err_o, clears done_o and leaves scan_en_o at 0. err_o stays set until a valid start.
- R9: After reset, scan_en_o, scan_in_o, done_o, err_o and patterns_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request pulse |
| target_i | input | $clog2(NUM_CHAINS)+1 | Index of the chain to stimulate |
| seed_i | input | 16 | Generator seed |
| chain_len_i | input | LEN_W | Shift cycles per pattern |
| pat_count_i | input | PAT_W | Patterns per run |
| scan_en_o | output | 1 | Scan enable to all chains |
| scan_in_o | output | NUM_CHAINS | Scan-in bit for each chain |
| patterns_o | output | PAT_W | Completed pattern count |
| done_o | output | 1 | Run finished |
| err_o | output | 1 | Last start refused for a bad index |

## Verification
The bench builds the block with its defaults: four chains, an 8-bit length field and a 10-bit pattern field. This leaves index values 4 to 7 available for the refusal path. It also lets a full 132-pattern run complete in a few hundred cycles. Because chain lengths of 1 and the zero-means-one cases are short, the boundaries where the pattern counter and the last-cycle decision coincide can be exercised. The wide seed field allows the zero-seed fallback and an all-ones seed to be compared against an independent model of the generator.

// File: rtl/rss_pkg.sv
package rss_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } rss_state_t;

    localparam int          GEN_W         = 16;
    localparam logic [15:0] GEN_MASK      = 16'hB400;
    localparam logic [15:0] SEED_FALLBACK = 16'hACE1;

    // Advance the Galois generator by one step.
    function automatic logic [GEN_W-1:0] gen_step(input logic [GEN_W-1:0] s);
        return s[0] ? ((s >> 1) ^ GEN_MASK) : (s >> 1);
    endfunction

    // A zero state would lock up, so substitute a fixed value.
    function automatic logic [GEN_W-1:0] gen_seed(input logic [GEN_W-1:0] s);
        return (s == '0) ? SEED_FALLBACK : s;
    endfunction

endpackage

// File: rtl/rss_lfsr.sv
module rss_lfsr
    import rss_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [GEN_W-1:0] seed_i,
    input  logic             adv_i,
    output logic             bit_o
);
    logic [GEN_W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= SEED_FALLBACK;
        else if (load_i)
            state_q <= gen_seed(seed_i);
        else if (adv_i)
            state_q <= gen_step(state_q);
    end

    assign bit_o = state_q[0];
endmodule

// File: rtl/rss_progress.sv
module rss_progress #(
    parameter int LEN_W = 8,
    parameter int PAT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             step_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [PAT_W-1:0] pats_i,
    output logic [PAT_W-1:0] patterns_o,
    output logic             last_o
);
    logic [LEN_W-1:0] shift_q;
    logic             pat_end;

    // len_i and pats_i are never zero here; the top clamps them.
    assign pat_end = (shift_q == len_i - LEN_W'(1));
    assign last_o  = pat_end && (patterns_o == pats_i - PAT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            shift_q    <= '0;
            patterns_o <= '0;
        end else if (step_i) begin
            if (pat_end) begin
                shift_q    <= '0;
                patterns_o <= patterns_o + PAT_W'(1);
            end else begin
                shift_q <= shift_q + LEN_W'(1);
            end
        end
    end
endmodule

// File: rtl/rss_steer.sv
module rss_steer #(
    parameter int NUM_CHAINS = 4,
    parameter int IDX_W      = 2
) (
    input  logic                  en_i,
    input  logic [IDX_W-1:0]      sel_i,
    input  logic                  bit_i,
    output logic [NUM_CHAINS-1:0] scan_o
);
    for (genvar g = 0; g < NUM_CHAINS; g++) begin : g_chain
        assign scan_o[g] = en_i && (sel_i == IDX_W'(g)) && bit_i;
    end
endmodule

// File: rtl/region_scan_gen.sv
module region_scan_gen
    import rss_pkg::*;
#(
    parameter int NUM_CHAINS = 4,
    parameter int LEN_W      = 8,
    parameter int PAT_W      = 10,
    localparam int IDX_W     = $clog2(NUM_CHAINS),
    localparam int SEL_W     = IDX_W + 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    input  logic [SEL_W-1:0]      target_i,
    input  logic [GEN_W-1:0]      seed_i,
    input  logic [LEN_W-1:0]      chain_len_i,
    input  logic [PAT_W-1:0]      pat_count_i,
    output logic                  scan_en_o,
    output logic [NUM_CHAINS-1:0] scan_in_o,
    output logic [PAT_W-1:0]      patterns_o,
    output logic                  done_o,
    output logic                  err_o
);
    rss_state_t       state_q;
    logic [IDX_W-1:0] tgt_q;
    logic [LEN_W-1:0] len_q;
    logic [PAT_W-1:0] pats_q;
    logic             in_range, accept, refuse, running, last, gen_bit;

    assign running  = (state_q == ST_RUN);
    assign in_range = (int'(target_i) < NUM_CHAINS);
    assign accept   = start_i && !running && in_range;
    assign refuse   = start_i && !running && !in_range;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            tgt_q   <= '0;
            len_q   <= LEN_W'(1);
            pats_q  <= PAT_W'(1);
            err_o   <= 1'b0;
        end else if (accept) begin
            state_q <= ST_RUN;
            tgt_q   <= target_i[IDX_W-1:0];
            len_q   <= (chain_len_i == '0) ? LEN_W'(1) : chain_len_i;
            pats_q  <= (pat_count_i == '0) ? PAT_W'(1) : pat_count_i;
            err_o   <= 1'b0;
        end else if (refuse) begin
            state_q <= ST_IDLE;
            err_o   <= 1'b1;
        end else if (running && last) begin
            state_q <= ST_DONE;
        end
    end

    rss_lfsr u_gen (
        .clk    (clk),
        .rst    (rst),
        .load_i (accept),
        .seed_i (seed_i),
        .adv_i  (running),
        .bit_o  (gen_bit)
    );

    rss_progress #(.LEN_W(LEN_W), .PAT_W(PAT_W)) u_prog (
        .clk        (clk),
        .rst        (rst),
        .clear_i    (accept),
        .step_i     (running),
        .len_i      (len_q),
        .pats_i     (pats_q),
        .patterns_o (patterns_o),
        .last_o     (last)
    );

    rss_steer #(.NUM_CHAINS(NUM_CHAINS), .IDX_W(IDX_W)) u_steer (
        .en_i   (running),
        .sel_i  (tgt_q),
        .bit_i  (gen_bit),
        .scan_o (scan_in_o)
    );

    assign scan_en_o = running;
    assign done_o    = (state_q == ST_DONE);
endmodule

// File: rtl/rss_checker.sv
module rss_checker #(
    parameter int NUM_CHAINS = 4,
    parameter int PAT_W      = 10,
    parameter int SEL_W      = 3
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  start_i,
    input logic [SEL_W-1:0]      target_i,
    input logic                  scan_en_o,
    input logic [NUM_CHAINS-1:0] scan_in_o,
    input logic [PAT_W-1:0]      patterns_o,
    input logic                  done_o,
    input logic                  err_o
);
    AST_SINGLE_ACTIVE_CHAIN: assert property (@(posedge clk) disable iff (rst)
        $onehot0(scan_in_o)); // R3

    AST_IDLE_INPUTS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !scan_en_o |-> (scan_in_o == '0)); // R6

    AST_ENABLE_CONTINUOUS: assert property (@(posedge clk) disable iff (rst)
        (scan_en_o && !done_o) |=> (scan_en_o || done_o)); // R4

    AST_DONE_HELD: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> done_o); // R6

    AST_REFUSED_START: assert property (@(posedge clk) disable iff (rst)
        (start_i && !scan_en_o && (int'(target_i) >= NUM_CHAINS)) |=> (err_o && !scan_en_o && !done_o)); // R8

    AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!scan_en_o && !start_i) |=> $stable(patterns_o)); // R5

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (scan_en_o && start_i && !done_o) |=> !err_o || $stable(err_o)); // R7
endmodule

bind region_scan_gen rss_checker #(
    .NUM_CHAINS (NUM_CHAINS),
    .PAT_W      (PAT_W),
    .SEL_W      (SEL_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .target_i   (target_i),
    .scan_en_o  (scan_en_o),
    .scan_in_o  (scan_in_o),
    .patterns_o (patterns_o),
    .done_o     (done_o),
    .err_o      (err_o)
);

// File: tb/region_scan_gen_tb_top.sv
module region_scan_gen_tb_top;
    localparam int N     = 4;
    localparam int LEN_W = 8;
    localparam int PAT_W = 10;
    localparam int SEL_W = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic [SEL_W-1:0] target_i = '0;
    logic [15:0]      seed_i = '0;
    logic [LEN_W-1:0] chain_len_i = '0;
    logic [PAT_W-1:0] pat_count_i = '0;
    logic             scan_en_o, done_o, err_o;
    logic [N-1:0]     scan_in_o;
    logic [PAT_W-1:0] patterns_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    region_scan_gen #(.NUM_CHAINS(N), .LEN_W(LEN_W), .PAT_W(PAT_W)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .target_i(target_i),
        .seed_i(seed_i), .chain_len_i(chain_len_i), .pat_count_i(pat_count_i),
        .scan_en_o(scan_en_o), .scan_in_o(scan_in_o), .patterns_o(patterns_o),
        .done_o(done_o), .err_o(err_o)
    );

    // Entry: {poke, target[2:0], seed[15:0], len[7:0], pats[9:0]}
    localparam int NV = 5;
    localparam logic [37:0] VEC [NV] = '{
        {1'b0, 3'd3, 16'h1234, 8'd3, 10'd132},
        {1'b0, 3'd0, 16'hFFFF, 8'd1, 10'd5},
        {1'b0, 3'd1, 16'h0000, 8'd4, 10'd3},
        {1'b0, 3'd2, 16'h8001, 8'd0, 10'd0},
        {1'b1, 3'd2, 16'h00A5, 8'd7, 10'd2}
    };

    // Generator model taken from the requirement text.
    function automatic logic [15:0] model_next(input logic [15:0] s);
        return s[0] ? ((s >> 1) ^ 16'hB400) : (s >> 1);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_case(input logic [37:0] v);
        logic        poke;
        int          tgt, len, pats, cycles, bad_bits, bad_other, bad_pat;
        logic [15:0] s;
        logic [N-1:0] want;
        poke = v[37];
        tgt  = int'(v[36:34]);
        s    = (v[33:18] == 16'h0) ? 16'hACE1 : v[33:18];
        len  = (v[17:10] == 8'd0) ? 1 : int'(v[17:10]);
        pats = (v[9:0] == 10'd0) ? 1 : int'(v[9:0]);
        @(negedge clk);
        start_i = 1'b1; target_i = v[36:34]; seed_i = v[33:18];
        chain_len_i = v[17:10]; pat_count_i = v[9:0];
        @(negedge clk);
        start_i = 1'b0;
        check(scan_en_o == 1'b1, "R1 enable after start", scan_en_o, 1);
        cycles = 0; bad_bits = 0; bad_other = 0; bad_pat = 0;
        while (scan_en_o && cycles < 5000) begin
            want = '0;
            want[tgt] = s[0];
            if (scan_in_o[tgt] != s[0]) bad_bits++;
            if ((scan_in_o & ~(N'(1) << tgt)) != '0) bad_other++;
            if (int'(patterns_o) != cycles / len) bad_pat++;
            s = model_next(s);
            cycles++;
            // R7: a start with a different target mid-run must be ignored
            if (poke && cycles == 2) begin
                start_i = 1'b1; target_i = 3'(((tgt + 1) % N)); seed_i = 16'h5555;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        check(bad_bits == 0, poke ? "R7 target chain stream kept" : "R2 target chain stream", bad_bits, 0);
        check(bad_other == 0, "R3 other chains zero", bad_other, 0);
        check(cycles == len * pats, "R4 enable span", cycles, len * pats);
        check(bad_pat == 0, "R5 pattern count during run", bad_pat, 0);
        check(int'(patterns_o) == pats, "R5 final pattern count", patterns_o, pats);
        check(done_o && scan_in_o == '0 && !scan_en_o, "R6 end state", {done_o, scan_en_o, scan_in_o}, 32'h20);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!scan_en_o && scan_in_o == '0 && !done_o && !err_o && patterns_o == '0,
              "R9 reset state", {scan_en_o, scan_in_o, done_o, err_o}, 0);

        for (int i = 0; i < NV; i++) run_case(VEC[i]);

        // R6: done held while idle
        repeat (5) @(negedge clk);
        check(done_o == 1'b1, "R6 done held", done_o, 1);

        // R8: bad index refused
        start_i = 1'b1; target_i = 3'd5; seed_i = 16'h1111;
        chain_len_i = 8'd2; pat_count_i = 10'd2;
        @(negedge clk);
        start_i = 1'b0;
        check(err_o == 1'b1, "R8 error raised", err_o, 1);
        check(done_o == 1'b0, "R8 done cleared", done_o, 0);
        repeat (4) @(negedge clk);
        check(!scan_en_o && scan_in_o == '0, "R8 no run", {scan_en_o, scan_in_o}, 0);

        // R8: valid start clears error
        start_i = 1'b1; target_i = 3'd0;
        @(negedge clk);
        start_i = 1'b0;
        check(err_o == 1'b0 && scan_en_o, "R8 error cleared by valid start", {err_o, scan_en_o}, 1);
        repeat (8) @(negedge clk);
        check(done_o && int'(patterns_o) == 2, "R5 short run finished", patterns_o, 2);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule